// File: doc/BRIEF.md
# Integer-N Synthesizer Digital Core

This block holds the digital part of an integer-N frequency synthesizer. One programmable counter divides the reference, and another divides the VCO. A phase-frequency detector compares the two divided edges and emits up/down correction pulses. The direction of those pulses can be swapped to suit the sign of the VCO tuning slope. At steady state the loop settles where f_vco = f_ref × M / R. For example, a 19.44 MHz reference with R = 54 gives a 360 kHz comparison rate, and M = 1007 then places the VCO at 362.52 MHz.

The block also does three smaller jobs:
- It passes a 2-bit charge-pump current code through.
- It raises a boost request while the loop is still acquiring. The boost can also be held on permanently.
- It qualifies lock over a run of comparisons and drives a lock pin. That pin can instead show the divided reference for test.

The reference and VCO edges arrive as one-cycle strobes, already synchronized to the block clock `clk`. The analog charge pump, loop filter and VCO sit outside the block.

Top module: `pll_digital_core`

## Requirements
- R1: The reference divider emits one pulse per `r_ratio` strobes on `ref_tick`; a ratio of 0 acts as 1. After reset or shutdown the stored ratio is 0, so the first strobe emits a pulse at once and loads the ratio.
- R2: The main divider does the same with `vco_tick` and `m_ratio` (14 bits; the reference ratio is 11 bits).
- R3: A new ratio written to a divider input is taken only at that divider's terminal count. The period already under way finishes with the old ratio.
- R4: A divided reference pulse sets the internal "up" state, and a divided VCO pulse sets the internal "down" state. Each becomes visible one cycle after the divider pulse.
- R5: When both states are set, both clear on the next cycle, so up and down are never high together for two cycles in a row. Divider pulses that land in that clearing cycle are dropped.
- R6: With `pd_pol` = 1, `up` carries the reference-leading state and `dn` carries the VCO-leading state. With `pd_pol` = 0 the two outputs are swapped.
- R7: `cp_code` repeats `cp_sel` while the loop is enabled. The codes 00, 01, 10 and 11 request 200, 260, 400 and 530 µA.
- R8: Each comparison is measured as the number of cycles in which exactly one of the two detector states is high. A comparison counts as good when that number is at most `lock_win`.
- R9: Lock is declared at the end of the 16th good comparison in a row. It clears at the end of any comparison that is not good.
- R10: `boost` is high when `turbo_en` = 1 and either the loop is not locked or `turbo_hold` = 1.
- R11: With `ld_mode` = 1, `lock_pin` shows the lock flag. With `ld_mode` = 0, it shows the divided reference pulse.
- R12: While `pll_on` = 0, strobes have no effect. From the next cycle, `up`, `dn` and the lock flag are low. `cp_code` and `boost` are 0 at once. The dividers restart from their post-reset state when the loop is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_tick | input | 1 | One-cycle strobe per reference edge |
| vco_tick | input | 1 | One-cycle strobe per VCO edge |
| m_ratio | input | 14 | Main divide ratio |
| r_ratio | input | 11 | Reference divide ratio |
| pll_on | input | 1 | 0 shuts down dividers, detector and lock logic |
| pd_pol | input | 1 | Detector polarity; 1 = positive tuning slope |
| cp_sel | input | 2 | Requested charge-pump current code |
| turbo_en | input | 1 | Enable acquisition boost |
| turbo_hold | input | 1 | Keep boost on after lock |
| ld_mode | input | 1 | 1 = lock flag on lock pin, 0 = test output |
| lock_win | input | 8 | Largest phase error, in cycles, counted as good |
| up | output | 1 | Pump-up pulse |
| dn | output | 1 | Pump-down pulse |
| cp_code | output | 2 | Charge-pump current code |
| boost | output | 1 | Boost current request |
| lock_pin | output | 1 | Lock flag or test output |

## Verification
A strobe on `ref_tick` or `vco_tick` shows up on the divider output one cycle later. The detector state, and so `up`/`dn`, follows one cycle after that. The clearing of a both-high pair comes a further cycle on. The lock flag, and with it `boost` and `lock_pin`, changes one cycle after the clearing cycle.

The bench drives every strobe on a falling edge and samples on a falling edge. Each check waits the exact count of rising edges implied by this chain. Comparisons are spaced far enough apart that one has finished before the next strobe arrives.

// File: rtl/pll_digital_core.sv
module pll_digital_core #(
  parameter int MW     = 14,
  parameter int RW     = 11,
  parameter int WW     = 8,
  parameter int LOCK_N = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_tick,
  input  logic          vco_tick,
  input  logic [MW-1:0] m_ratio,
  input  logic [RW-1:0] r_ratio,
  input  logic          pll_on,
  input  logic          pd_pol,
  input  logic [1:0]    cp_sel,
  input  logic          turbo_en,
  input  logic          turbo_hold,
  input  logic          ld_mode,
  input  logic [WW-1:0] lock_win,
  output logic          up,
  output logic          dn,
  output logic [1:0]    cp_code,
  output logic          boost,
  output logic          lock_pin
);
  localparam int EW = WW + 2;
  localparam int GW = $clog2(LOCK_N);

  logic [RW-1:0] r_cnt, r_lim;
  logic [MW-1:0] m_cnt, m_lim;
  logic          r_pulse, m_pulse;
  logic          up_q, dn_q;
  logic [EW-1:0] err_cnt;
  logic [GW-1:0] good_cnt;
  logic          locked;

  wire [RW-1:0] r_end = (r_lim == '0) ? '0 : r_lim - 1'b1;
  wire [MW-1:0] m_end = (m_lim == '0) ? '0 : m_lim - 1'b1;
  wire          clr   = up_q & dn_q;
  wire          good  = err_cnt <= {2'b00, lock_win};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_cnt <= '0; r_lim <= '0; r_pulse <= 1'b0;
    end else if (!pll_on) begin
      r_cnt <= '0; r_lim <= '0; r_pulse <= 1'b0;
    end else begin
      r_pulse <= 1'b0;
      if (ref_tick) begin
        if (r_cnt == r_end) begin
          r_cnt   <= '0;
          r_lim   <= r_ratio;
          r_pulse <= 1'b1;
        end else begin
          r_cnt <= r_cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0; m_lim <= '0; m_pulse <= 1'b0;
    end else if (!pll_on) begin
      m_cnt <= '0; m_lim <= '0; m_pulse <= 1'b0;
    end else begin
      m_pulse <= 1'b0;
      if (vco_tick) begin
        if (m_cnt == m_end) begin
          m_cnt   <= '0;
          m_lim   <= m_ratio;
          m_pulse <= 1'b1;
        end else begin
          m_cnt <= m_cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0; dn_q <= 1'b0;
    end else if (!pll_on || clr) begin
      up_q <= 1'b0; dn_q <= 1'b0;
    end else begin
      up_q <= up_q | r_pulse;
      dn_q <= dn_q | m_pulse;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_cnt <= '0;
    end else if (!pll_on || clr) begin
      err_cnt <= '0;
    end else if ((up_q ^ dn_q) && err_cnt != '1) begin
      err_cnt <= err_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_cnt <= '0; locked <= 1'b0;
    end else if (!pll_on) begin
      good_cnt <= '0; locked <= 1'b0;
    end else if (clr) begin
      if (good) begin
        if (good_cnt == GW'(LOCK_N - 1)) locked <= 1'b1;
        else good_cnt <= good_cnt + 1'b1;
      end else begin
        good_cnt <= '0;
        locked   <= 1'b0;
      end
    end
  end

  assign up       = pd_pol ? up_q : dn_q;
  assign dn       = pd_pol ? dn_q : up_q;
  assign cp_code  = pll_on ? cp_sel : 2'b00;
  assign boost    = pll_on & turbo_en & (turbo_hold | ~locked);
  assign lock_pin = ld_mode ? locked : r_pulse;
endmodule

module pll_digital_core_chk #(
  parameter int EW = 10,
  parameter int WW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pll_on,
  input logic          up,
  input logic          dn,
  input logic          locked,
  input logic          clr,
  input logic [EW-1:0] err_cnt,
  input logic [WW-1:0] lock_win
);
  // R5
  both_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up && dn) |=> (!up && !dn));

  // R12
  shutdown_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_on |=> (!up && !dn && !locked));

  // R9
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && (err_cnt > {2'b00, lock_win})) |=> !locked);

  // R9
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(clr));
endmodule

bind pll_digital_core pll_digital_core_chk #(.EW(EW), .WW(WW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pll_on(pll_on), .up(up), .dn(dn),
  .locked(locked), .clr(clr), .err_cnt(err_cnt), .lock_win(lock_win)
);

// File: tb/pll_digital_core_tb.sv
module pll_digital_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0, vco_tick = 1'b0;
  logic [13:0] m_ratio = 14'd1;
  logic [10:0] r_ratio = 11'd1;
  logic        pll_on = 1'b1, pd_pol = 1'b1;
  logic [1:0]  cp_sel = 2'b00;
  logic        turbo_en = 1'b0, turbo_hold = 1'b0, ld_mode = 1'b1;
  logic [7:0]  lock_win = 8'd2;
  logic        up, dn, boost, lock_pin;
  logic [1:0]  cp_code;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  pll_digital_core u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .vco_tick(vco_tick),
    .m_ratio(m_ratio), .r_ratio(r_ratio), .pll_on(pll_on), .pd_pol(pd_pol),
    .cp_sel(cp_sel), .turbo_en(turbo_en), .turbo_hold(turbo_hold),
    .ld_mode(ld_mode), .lock_win(lock_win), .up(up), .dn(dn),
    .cp_code(cp_code), .boost(boost), .lock_pin(lock_pin)
  );

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ref_tick = 1'b0; vco_tick = 1'b0; pll_on = 1'b1;
    pd_pol = 1'b1; ld_mode = 1'b1; turbo_en = 1'b0; turbo_hold = 1'b0;
    m_ratio = 14'd1; r_ratio = 11'd1; lock_win = 8'd2; cp_sel = 2'b00;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic vtick();
    vco_tick = 1'b1; step(); vco_tick = 1'b0; step();
  endtask

  task automatic rclear();
    ref_tick = 1'b1; step(); ref_tick = 1'b0; step(); step();
  endtask

  task automatic comp(input int d);
    ref_tick = 1'b1; vco_tick = (d == 0); step();
    ref_tick = 1'b0; vco_tick = 1'b0;
    if (d > 0) begin
      repeat (d - 1) step();
      vco_tick = 1'b1; step(); vco_tick = 1'b0;
    end
    repeat (4) step();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R12", "up after reset", up, 0);
    chk("R12", "dn after reset", dn, 0);
    chk("R11", "lock_pin after reset", lock_pin, 0);
  endtask

  task automatic t_ref_div();
    do_reset();
    ld_mode = 1'b0; r_ratio = 11'd3;
    ref_tick = 1'b1; step(); ref_tick = 1'b0;
    chk("R1", "first strobe pulse", lock_pin, 1);
    for (int k = 1; k <= 3; k++) begin
      ref_tick = 1'b1; step(); ref_tick = 1'b0;
      chk("R11", $sformatf("test pin after strobe %0d", k), lock_pin, (k == 3) ? 1 : 0);
    end
  endtask

  task automatic t_fb_div();
    do_reset();
    m_ratio = 14'd5;
    comp(0);
    for (int k = 1; k <= 5; k++) begin
      vtick();
      chk("R2", $sformatf("dn after vco strobe %0d", k), dn, (k == 5) ? 1 : 0);
    end
    rclear();
    chk("R4", "dn cleared by reference", dn, 0);
    for (int k = 1; k <= 5; k++) begin
      if (k == 3) m_ratio = 14'd3;
      vtick();
      chk("R3", $sformatf("old ratio, strobe %0d", k), dn, (k == 5) ? 1 : 0);
    end
    rclear();
    for (int k = 1; k <= 3; k++) begin
      vtick();
      chk("R3", $sformatf("new ratio, strobe %0d", k), dn, (k == 3) ? 1 : 0);
    end
  endtask

  task automatic t_both();
    do_reset();
    ref_tick = 1'b1; vco_tick = 1'b1; step();
    ref_tick = 1'b0; vco_tick = 1'b0; step();
    chk("R5", "up with coincident edges", up, 1);
    chk("R5", "dn with coincident edges", dn, 1);
    step();
    chk("R5", "up after clearing", up, 0);
    chk("R5", "dn after clearing", dn, 0);
  endtask

  task automatic t_pol();
    do_reset();
    pd_pol = 1'b0;
    ref_tick = 1'b1; step(); ref_tick = 1'b0; step();
    chk("R6", "dn with swapped polarity", dn, 1);
    chk("R6", "up with swapped polarity", up, 0);
    pd_pol = 1'b1; #1;
    chk("R4", "up with positive polarity", up, 1);
    chk("R6", "dn with positive polarity", dn, 0);
  endtask

  task automatic t_lock();
    do_reset();
    turbo_en = 1'b1; lock_win = 8'd2; cp_sel = 2'b10;
    #1;
    chk("R7", "cp_code pass-through", cp_code, 2);
    for (int k = 0; k < 15; k++) comp(0);
    chk("R9", "no lock after 15 good", lock_pin, 0);
    chk("R10", "boost while acquiring", boost, 1);
    comp(0);
    chk("R9", "lock after 16 good", lock_pin, 1);
    chk("R10", "boost off after lock", boost, 0);
    turbo_hold = 1'b1; #1;
    chk("R10", "boost held after lock", boost, 1);
    comp(2);
    chk("R8", "error equal to window keeps lock", lock_pin, 1);
    comp(3);
    chk("R8", "error beyond window drops lock", lock_pin, 0);
    for (int k = 0; k < 15; k++) comp(0);
    chk("R9", "no relock after 15 good", lock_pin, 0);
    comp(0);
    chk("R9", "relock after 16 good", lock_pin, 1);
  endtask

  task automatic t_shutdown();
    do_reset();
    turbo_en = 1'b1; cp_sel = 2'b11; r_ratio = 11'd3;
    ref_tick = 1'b1; step(); ref_tick = 1'b0; step();
    chk("R4", "up before shutdown", up, 1);
    pll_on = 1'b0; #1;
    chk("R12", "cp_code in shutdown", cp_code, 0);
    chk("R12", "boost in shutdown", boost, 0);
    step();
    chk("R12", "up in shutdown", up, 0);
    ref_tick = 1'b1; vco_tick = 1'b1; step();
    ref_tick = 1'b0; vco_tick = 1'b0; step();
    chk("R12", "up ignores strobes in shutdown", up, 0);
    chk("R12", "dn ignores strobes in shutdown", dn, 0);
    pll_on = 1'b1; ld_mode = 1'b0; step();
    ref_tick = 1'b1; step(); ref_tick = 1'b0;
    chk("R12", "divider restarts after enable", lock_pin, 1);
  endtask

  initial begin
    t_reset();
    t_ref_div();
    t_fb_div();
    t_both();
    t_pol();
    t_lock();
    t_shutdown();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule